// File: doc/BRIEF.md
# Memory PHY Training Sequencer

This block steps the physical layer of a memory channel through its calibration phases, one rank at a time. Software controls it through a small set of register fields. These are a rank number, a requested-phase field, a mode bit that selects manual control, and a start strobe. The block sends the active phase code and the latched rank to the training engines. Each engine answers with a one-cycle done pulse when its phase is finished. Software runs the whole chain once for every populated rank.

In automatic mode a single start strobe runs the full chain. The chain is read-strobe centering, then receive-enable lock, then write leveling, then write-strobe centering, and then the block returns to idle. In manual mode the phase follows the requested-phase field, so software can run, repeat or abort any single phase. In both modes a watchdog counter guards each phase. If an engine stops answering, the block raises an error flag and returns to idle.

Top module: `phy_train_seq`

## Requirements
- R1: The reset state is idle. After a synchronous reset, `phase_out` is 0, `rank_out` is 0, and `busy`, `complete` and `timeout_err` are all 0.
- R2: In automatic mode (`manual_mode`=0), a `start` pulse while idle sets `phase_out` to 1 (read-strobe centering) on the next clock edge. On that same edge, `busy` goes to 1, `rank_out` takes the value of `rank_sel`, and `timeout_err` is cleared.
- R3: In automatic mode the phase codes run 1→2→3→4 in that order. The phase advances only on an edge where `phase_done` is 1. Otherwise the phase is held. A `phase_done` pulse while idle has no effect.
- R4: In automatic mode, `phase_done` in phase 4 (write-strobe centering) returns `phase_out` to 0 and drops `busy`. On that same edge, `complete` goes high for exactly one cycle.
- R5: A `start` pulse while `phase_out` is not 0 is ignored. Changes to `rank_sel` do not alter `rank_out` while a sequence is running.
- R6: In manual mode (`manual_mode`=1), `phase_out` takes the value of `next_phase` one clock edge later. In this mode `phase_done` does not move the phase, and `start` is ignored.
- R7: In manual mode, `next_phase` codes 5, 6 and 7 are treated as idle (0). Setting `next_phase` to 0 aborts the running phase, and `busy` falls on the same edge.
- R8: Each non-idle phase has a watchdog limit of `TIMEOUT_CYCLES`. If `TIMEOUT_CYCLES` clock edges pass in one phase with no `phase_done`, then on the last of those edges `phase_out` returns to 0 and `timeout_err` is set. `timeout_err` stays set until the next automatic start.
- R9: After a watchdog expiry in manual mode, the block stays idle until software sets `next_phase` to 0. After that, a non-zero `next_phase` starts a phase again.
- R10: In manual mode, entering a non-idle phase from idle loads `rank_out` from `rank_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rank_sel | input | RANK_W | Rank to train, captured when a sequence starts |
| next_phase | input | 3 | Requested phase code used in manual mode |
| manual_mode | input | 1 | 1 = software-driven phases, 0 = automatic chain |
| start | input | 1 | One-cycle strobe that launches the automatic chain |
| phase_done | input | 1 | One-cycle done pulse from the active phase engine |
| phase_out | output | 3 | Current phase: 0 idle, 1 read centering, 2 receive-enable lock, 3 write leveling, 4 write centering |
| rank_out | output | RANK_W | Rank under training |
| busy | output | 1 | High while the phase is not idle |
| complete | output | 1 | One-cycle pulse when the automatic chain ends |
| timeout_err | output | 1 | Sticky watchdog error flag |

## Verification
The automatic chain is run with a done pulse on every cycle, and again with idle gaps between done pulses. The first run shows that advancing is driven by done rather than by time, and the gaps show that the phase holds while waiting. Manual mode is driven with legal codes, illegal codes, zero, and stray done and start pulses. These patterns separate a design that follows the field from one that still advances by itself or decodes out-of-range codes. A silent engine is modelled in both modes to expose the watchdog boundary at its exact cycle. The bench also checks the error recovery path and the manual lockout.

// File: rtl/phy_train_pkg.sv
package phy_train_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_RD_CENTER = 3'd1,
    PH_RCV_LOCK  = 3'd2,
    PH_WR_LEVEL  = 3'd3,
    PH_WR_CENTER = 3'd4
  } phase_e;

  localparam logic [2:0] PH_LAST_CODE = 3'd4;

  // Out-of-range codes map to idle.
  function automatic phase_e phase_legalize(input logic [2:0] raw);
    phase_e p;
    if (raw <= PH_LAST_CODE) p = phase_e'(raw);
    else                     p = PH_IDLE;
    return p;
  endfunction

  // Successor in the automatic chain; the final phase wraps to idle.
  function automatic phase_e phase_succ(input phase_e cur);
    phase_e p;
    case (cur)
      PH_RD_CENTER: p = PH_RCV_LOCK;
      PH_RCV_LOCK:  p = PH_WR_LEVEL;
      PH_WR_LEVEL:  p = PH_WR_CENTER;
      default:      p = PH_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/phy_train_timer.sv
module phy_train_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic done,
  input  logic kick,
  output logic expire
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  // Expiry looks only at the count and the done pulse, never at kick,
  // so there is no loop through the phase decision.
  assign expire = active && !done && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || kick || !active) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/phy_train_ctrl.sv
module phy_train_ctrl
  import phy_train_pkg::*;
(
  input  phase_e     phase_q,
  input  logic       manual,
  input  logic [2:0] req_code,
  input  logic       start,
  input  logic       done,
  input  logic       expire,
  input  logic       lock_q,
  output phase_e     phase_d,
  output logic       load_rank,
  output logic       finish,
  output logic       set_err,
  output logic       clr_err,
  output logic       lock_d
);
  phase_e req;

  always_comb begin
    req       = phase_legalize(req_code);
    phase_d   = phase_q;
    load_rank = 1'b0;
    finish    = 1'b0;
    set_err   = 1'b0;
    clr_err   = 1'b0;
    lock_d    = lock_q;

    if (!manual) begin
      lock_d = 1'b0;
      if (expire) begin
        phase_d = PH_IDLE;
        set_err = 1'b1;
      end else if (phase_q == PH_IDLE) begin
        if (start) begin
          phase_d   = PH_RD_CENTER;
          load_rank = 1'b1;
          clr_err   = 1'b1;
        end
      end else if (done) begin
        phase_d = phase_succ(phase_q);
        finish  = (phase_q == PH_WR_CENTER);
      end
    end else begin
      if (expire) begin
        phase_d = PH_IDLE;
        set_err = 1'b1;
        lock_d  = 1'b1;
      end else if (lock_q) begin
        phase_d = PH_IDLE;
        if (req == PH_IDLE) lock_d = 1'b0;
      end else begin
        phase_d   = req;
        load_rank = (phase_q == PH_IDLE) && (req != PH_IDLE);
      end
    end
  end
endmodule

// File: rtl/phy_train_seq.sv
module phy_train_seq
  import phy_train_pkg::*;
#(
  parameter int RANK_W         = 3,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RANK_W-1:0] rank_sel,
  input  logic [2:0]        next_phase,
  input  logic              manual_mode,
  input  logic              start,
  input  logic              phase_done,
  output logic [2:0]        phase_out,
  output logic [RANK_W-1:0] rank_out,
  output logic              busy,
  output logic              complete,
  output logic              timeout_err
);
  phase_e            phase_q, phase_d;
  logic [RANK_W-1:0] rank_q;
  logic              busy_q, cmp_q, err_q, lock_q;
  logic              load_rank, finish, set_err, clr_err, lock_d;
  logic              tmr_expire, tmr_kick;

  assign tmr_kick = phase_done || (phase_d != phase_q);

  phy_train_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (phase_q != PH_IDLE),
    .done   (phase_done),
    .kick   (tmr_kick),
    .expire (tmr_expire)
  );

  phy_train_ctrl u_ctrl (
    .phase_q   (phase_q),
    .manual    (manual_mode),
    .req_code  (next_phase),
    .start     (start),
    .done      (phase_done),
    .expire    (tmr_expire),
    .lock_q    (lock_q),
    .phase_d   (phase_d),
    .load_rank (load_rank),
    .finish    (finish),
    .set_err   (set_err),
    .clr_err   (clr_err),
    .lock_d    (lock_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      rank_q  <= '0;
      busy_q  <= 1'b0;
      cmp_q   <= 1'b0;
      err_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      busy_q  <= (phase_d != PH_IDLE);
      cmp_q   <= finish;
      lock_q  <= lock_d;
      if (load_rank) rank_q <= rank_sel;
      if (set_err)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  assign phase_out   = phase_q;
  assign rank_out    = rank_q;
  assign busy        = busy_q;
  assign complete    = cmp_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/phy_train_chk.sv
module phy_train_chk #(
  parameter int RANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        next_phase,
  input logic              manual_mode,
  input logic              start,
  input logic              phase_done,
  input logic [2:0]        phase_out,
  input logic [RANK_W-1:0] rank_out,
  input logic              busy,
  input logic              complete,
  input logic              timeout_err,
  input logic              tmr_expire
);
  assert_busy_tracks_phase_R1: assert property (@(posedge clk) disable iff (rst)
    busy == (phase_out != 3'd0));

  assert_legal_phase_R7: assert property (@(posedge clk) disable iff (rst)
    phase_out <= 3'd4);

  assert_auto_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (!manual_mode && phase_out == 3'd0 && start) |=> (phase_out == 3'd1 && busy && !timeout_err));

  assert_auto_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!manual_mode && phase_out != 3'd0 && !phase_done && !tmr_expire) |=> $stable(phase_out));

  assert_complete_idle_R4: assert property (@(posedge clk) disable iff (rst)
    complete |-> (phase_out == 3'd0 && !busy));

  assert_complete_single_R4: assert property (@(posedge clk) disable iff (rst)
    complete |=> !complete);

  assert_rank_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_out != 3'd0) |=> (phase_out == 3'd0 || $stable(rank_out)));

  assert_illegal_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (manual_mode && next_phase > 3'd4) |=> (phase_out == 3'd0));

  assert_expire_error_R8: assert property (@(posedge clk) disable iff (rst)
    tmr_expire |=> (timeout_err && phase_out == 3'd0));
endmodule

bind phy_train_seq phy_train_chk #(.RANK_W(RANK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .next_phase  (next_phase),
  .manual_mode (manual_mode),
  .start       (start),
  .phase_done  (phase_done),
  .phase_out   (phase_out),
  .rank_out    (rank_out),
  .busy        (busy),
  .complete    (complete),
  .timeout_err (timeout_err),
  .tmr_expire  (tmr_expire)
);

// File: tb/test_phy_train_seq.sv
module test_phy_train_seq;
  localparam int RW = 3;
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] rank_sel = '0;
  logic [2:0]    next_phase = '0;
  logic          manual_mode = 1'b0;
  logic          start = 1'b0;
  logic          phase_done = 1'b0;
  logic [2:0]    phase_out;
  logic [RW-1:0] rank_out;
  logic          busy, complete, timeout_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  phy_train_seq #(.RANK_W(RW), .TIMEOUT_CYCLES(TMO)) i_phy_train_seq (
    .clk(clk), .rst(rst), .rank_sel(rank_sel), .next_phase(next_phase),
    .manual_mode(manual_mode), .start(start), .phase_done(phase_done),
    .phase_out(phase_out), .rank_out(rank_out), .busy(busy),
    .complete(complete), .timeout_err(timeout_err)
  );

  typedef struct packed {
    logic       st;
    logic       dn;
    logic       man;
    logic [2:0] nxt;
    logic [2:0] rk;
    logic [2:0] e_ph;
    logic       e_busy;
    logic       e_cmp;
    logic [2:0] e_rk;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,3'd0,3'd5, 3'd1,1'b1,1'b0,3'd5}, // R2 launch, rank 5 latched
    '{1'b1,1'b0,1'b0,3'd0,3'd2, 3'd1,1'b1,1'b0,3'd5}, // R5 start while busy, rank write
    '{1'b0,1'b1,1'b0,3'd0,3'd2, 3'd2,1'b1,1'b0,3'd5}, // R3 1->2
    '{1'b0,1'b0,1'b0,3'd0,3'd2, 3'd2,1'b1,1'b0,3'd5}, // R3 hold without done
    '{1'b0,1'b1,1'b0,3'd0,3'd2, 3'd3,1'b1,1'b0,3'd5}, // R3 2->3
    '{1'b0,1'b1,1'b0,3'd0,3'd2, 3'd4,1'b1,1'b0,3'd5}, // R3 3->4
    '{1'b0,1'b1,1'b0,3'd0,3'd2, 3'd0,1'b0,1'b1,3'd5}, // R4 finish pulse
    '{1'b0,1'b0,1'b0,3'd0,3'd2, 3'd0,1'b0,1'b0,3'd5}, // R4 pulse is one cycle
    '{1'b0,1'b0,1'b1,3'd3,3'd6, 3'd3,1'b1,1'b0,3'd6}, // R6 R10 manual entry
    '{1'b0,1'b1,1'b1,3'd3,3'd6, 3'd3,1'b1,1'b0,3'd6}, // R6 done ignored
    '{1'b0,1'b0,1'b1,3'd6,3'd6, 3'd0,1'b0,1'b0,3'd6}, // R7 illegal code -> idle
    '{1'b0,1'b0,1'b1,3'd4,3'd1, 3'd4,1'b1,1'b0,3'd1}, // R10 rank reloaded
    '{1'b1,1'b0,1'b1,3'd0,3'd1, 3'd0,1'b0,1'b0,3'd1}, // R7 abort, R6 start ignored
    '{1'b0,1'b1,1'b0,3'd0,3'd1, 3'd0,1'b0,1'b0,3'd1}  // R3 done while idle
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic state(input string tag, input int ph, input int bz, input int cp, input int er);
    chk(tag, "phase", phase_out, ph);
    chk(tag, "busy", busy, bz);
    chk(tag, "complete", complete, cp);
    chk(tag, "error", timeout_err, er);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R1 reset state
    state("R1", 0, 0, 0, 0);
    chk("R1", "rank", rank_out, 0);

    for (int i = 0; i < NV; i++) begin
      start = TBL[i].st; phase_done = TBL[i].dn; manual_mode = TBL[i].man;
      next_phase = TBL[i].nxt; rank_sel = TBL[i].rk;
      step();
      chk($sformatf("row%0d", i), "phase", phase_out, TBL[i].e_ph);
      chk($sformatf("row%0d", i), "busy", busy, TBL[i].e_busy);
      chk($sformatf("row%0d", i), "complete", complete, TBL[i].e_cmp);
      chk($sformatf("row%0d", i), "rank", rank_out, TBL[i].e_rk);
    end
    start = 0; phase_done = 0; manual_mode = 0; next_phase = 0;

    // R8 automatic watchdog at the exact boundary
    rank_sel = 3; start = 1; step(); start = 0;
    state("R2", 1, 1, 0, 0);
    repeat (TMO - 1) step();
    state("R8", 1, 1, 0, 0);
    step();
    state("R8", 0, 0, 0, 1);
    step();
    state("R8", 0, 0, 0, 1);
    // restart clears the error; full chain with gaps
    rank_sel = 7; start = 1; step(); start = 0;
    state("R8", 1, 1, 0, 0);
    chk("R2", "rank", rank_out, 7);
    for (int p = 2; p <= 5; p++) begin
      step();
      phase_done = 1; step(); phase_done = 0;
      state("R3", (p == 5) ? 0 : p, (p == 5) ? 0 : 1, (p == 5) ? 1 : 0, 0);
    end

    // R9 manual watchdog and lockout
    manual_mode = 1; next_phase = 2; rank_sel = 4; step();
    state("R6", 2, 1, 0, 0);
    chk("R10", "rank", rank_out, 4);
    repeat (TMO - 1) step();
    state("R8", 2, 1, 0, 0);
    step();
    state("R9", 0, 0, 0, 1);
    step();
    state("R9", 0, 0, 0, 1);
    next_phase = 0; step();
    state("R9", 0, 0, 0, 1);
    next_phase = 2; step();
    state("R9", 2, 1, 0, 1);
    next_phase = 0; step();
    state("R7", 0, 0, 0, 1);
    manual_mode = 0; start = 1; step(); start = 0;
    state("R8", 1, 1, 0, 0);

    // R1 reset mid-run
    rst = 1; step(); rst = 0;
    state("R1", 0, 0, 0, 0);
    chk("R1", "rank", rank_out, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule